// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides, for one executing load at a time, whether the load's data can come from an older store that has not yet been written to memory. It reads the store queue through a one-entry read port, one entry per cycle. It starts at the youngest store older than the load and moves toward older entries, wrapping around the circular queue, until it reaches the writeback pointer. The load is resolved in one of five ways. It takes forwarded bytes from a store that fully covers it. It is told to retry when a live store only partly overlaps it. It goes to the cache, or is reported blocked when the cache cannot take it. An uncacheable load that is not yet eligible gets a fault.

A single stall record names the oldest load that has been sent back by a partial overlap, together with the sequence number of the store it waits on. A sticky blocked flag reports a load turned away by a busy cache until it is acknowledged. The controller is a three-state machine. ST_IDLE accepts a load. It takes ST_IDLE→ST_SCAN for a normal load and ST_IDLE→ST_RESP for an ineligible uncacheable load. ST_SCAN examines one entry per cycle and stays in ST_SCAN→ST_SCAN while entries are skipped. It leaves by ST_SCAN→ST_RESP once a decision is made. ST_RESP presents the result for one cycle and returns by ST_RESP→ST_IDLE.

Top module: `fwd_check_top`

## Requirements
- R1: After reset, busy, rsp_valid, stall_active and ld_blocked are all 0.
- R2: A load with ld_uncache=1 and not (ld_at_head=1 and ld_commit_ok=1) gets rsp_kind=3 (fault) with no store search. An uncacheable load that is at the head and ready is searched like any other.
- R3: The search examines entries ld_sq_idx−1, ld_sq_idx−2, … modulo the queue depth. The entry at wb_ptr is included, and no entry beyond it is examined. If ld_sq_idx equals wb_ptr, nothing is examined. The first deciding entry in this youngest-first order wins.
- R4: A store entry with size 0 never matches and the search continues past it.
- R5: The load range [addr, addr+size) may lie fully inside a store range [st_addr, st_addr+st_size). In that case the result is rsp_kind=1 (forward), and this holds even if the store has already been written back. rsp_data is the store data shifted right by 8×(ld_addr AND (st_size−1)) bits. Bytes at or above the load size are zeroed.
- R6: If the ranges overlap without containment and the store's done flag is 0, the result is rsp_kind=2 (retry). If the done flag is 1, that entry is skipped.
- R7: On a retry, the stall record (stall_active, stall_store_seq, stall_load_idx) is written only if it is inactive or the load's ld_seq is smaller than that of the recorded load. A stall_release pulse clears stall_active.
- R8: If the search ends with no decision, the result is rsp_kind=0 (cache access) when cache_blocked=0. It is rsp_kind=4 (blocked) when cache_blocked=1, and ld_blocked is then set. ld_blocked stays 1 until a blk_ack pulse clears it.
- R9: rsp_valid is a one-cycle pulse. A fault appears in the first cycle after the load is accepted. Any other result appears in the cycle after the scan step that decided it, so a hit on the first examined entry appears two cycles after acceptance. busy is 1 from acceptance until the response cycle ends, and ld_req is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_req | input | 1 | Start a check for the load on the ld_* inputs |
| ld_addr | input | AW | Load byte address |
| ld_size | input | SZW | Load size in bytes (1 to DW/8) |
| ld_sq_idx | input | SQW | Store-queue slot just younger than the load's youngest older store |
| ld_idx | input | LQW | Load-queue index of the load |
| ld_seq | input | SEQW | Age of the load (smaller is older) |
| ld_uncache | input | 1 | Load targets uncacheable space |
| ld_at_head | input | 1 | Load is at the load-queue head |
| ld_commit_ok | input | 1 | Load is ready to commit |
| wb_ptr | input | SQW | Oldest store not yet written back |
| cache_blocked | input | 1 | Cache cannot accept a request |
| sq_rd_idx | output | SQW | Store-queue entry being read |
| sq_rd_addr | input | AW | Store address of the read entry |
| sq_rd_size | input | SZW | Store size in bytes (0 = no data) |
| sq_rd_data | input | DW | Store data of the read entry |
| sq_rd_done | input | 1 | Read entry has completed writeback |
| sq_rd_seq | input | SEQW | Sequence number of the read entry |
| busy | output | 1 | A load is being processed |
| rsp_valid | output | 1 | Result valid this cycle |
| rsp_kind | output | 3 | 0 cache, 1 forward, 2 retry, 3 fault, 4 blocked |
| rsp_data | output | DW | Forwarded data (0 for other kinds) |
| ld_blocked | output | 1 | Sticky flag: a load found the cache blocked |
| blk_ack | input | 1 | Clears ld_blocked |
| stall_active | output | 1 | Stall record holds a load |
| stall_store_seq | output | SEQW | Sequence number of the store the stalled load waits on |
| stall_load_idx | output | LQW | Load-queue index of the stalled load |
| stall_release | input | 1 | Clears the stall record |

## Verification
The loads are run against one store-queue image that holds stores of mixed sizes: a zero-size slot, a written-back store, and two stores that overlap each other. One load sees nested stores, so only youngest-first order gives the right result. Others touch a range from below and from above, which separates containment from partial overlap. The same partial overlap is tried against a completed store and a live store, which separates skipping from retrying. The loads carry ascending and descending ages, which separates a record update from a record hold. Moving wb_ptr wraps the scan, cuts it short, or empties it, which shows where the scan stops.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [2:0] {
        OUT_MEM     = 3'd0,
        OUT_FWD     = 3'd1,
        OUT_RETRY   = 3'd2,
        OUT_FAULT   = 3'd3,
        OUT_BLOCKED = 3'd4
    } outcome_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_RESP = 2'd2
    } fsm_e;

    typedef enum logic [1:0] {
        OV_NONE = 2'd0,
        OV_FULL = 2'd1,
        OV_PART = 2'd2
    } overlap_e;

endpackage

// File: rtl/fwd_overlap.sv
module fwd_overlap
    import fwd_pkg::*;
#(
    parameter int AW  = 16,
    parameter int SZW = 4
) (
    input  logic [AW-1:0]  ld_addr,
    input  logic [SZW-1:0] ld_size,
    input  logic [AW-1:0]  st_addr,
    input  logic [SZW-1:0] st_size,
    output overlap_e       ov
);
    localparam int EW = AW + 1;

    logic [EW-1:0] ld_lo, ld_hi, st_lo, st_hi;
    logic lo_inside, hi_inside, lo_touch, hi_touch;

    always_comb begin
        ld_lo = {1'b0, ld_addr};
        st_lo = {1'b0, st_addr};
        ld_hi = ld_lo + EW'(ld_size);
        st_hi = st_lo + EW'(st_size);
        lo_inside = (ld_lo >= st_lo);
        hi_inside = (ld_hi <= st_hi);
        lo_touch  = (ld_lo <  st_hi);
        hi_touch  = (ld_hi >  st_lo);
        if (st_size == '0) begin
            ov = OV_NONE;
        end else if (lo_inside && hi_inside) begin
            ov = OV_FULL;
        end else if ((lo_inside && lo_touch) || (hi_inside && hi_touch) ||
                     (lo_touch && hi_touch)) begin
            ov = OV_PART;
        end else begin
            ov = OV_NONE;
        end
    end
endmodule

// File: rtl/fwd_align.sv
module fwd_align #(
    parameter int AW  = 16,
    parameter int DW  = 64,
    parameter int SZW = 4
) (
    input  logic [DW-1:0]  st_data,
    input  logic [SZW-1:0] st_size,
    input  logic [AW-1:0]  ld_addr,
    input  logic [SZW-1:0] ld_size,
    output logic [DW-1:0]  fwd_data
);
    localparam int NB   = DW / 8;
    localparam int OFFW = (NB > 1) ? $clog2(NB) : 1;

    logic [SZW-1:0]  size_m1;
    logic [OFFW-1:0] byte_off;
    logic [DW-1:0]   shifted;

    always_comb begin
        size_m1  = st_size - SZW'(1);
        byte_off = ld_addr[OFFW-1:0] & size_m1[OFFW-1:0];
        shifted  = st_data >> {byte_off, 3'b000};
    end

    for (genvar b = 0; b < NB; b++) begin : g_mask
        assign fwd_data[b*8 +: 8] = (SZW'(b) < ld_size) ? shifted[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/fwd_stall_rec.sv
module fwd_stall_rec #(
    parameter int SEQW = 16,
    parameter int LQW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retry_evt,
    input  logic [SEQW-1:0] ld_seq,
    input  logic [LQW-1:0]  ld_idx,
    input  logic [SEQW-1:0] st_seq,
    input  logic            release_i,
    output logic            active,
    output logic [SEQW-1:0] store_seq,
    output logic [LQW-1:0]  load_idx
);
    logic [SEQW-1:0] load_seq_q;
    logic            take;

    assign take = retry_evt && (!active || (ld_seq < load_seq_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active     <= 1'b0;
            store_seq  <= '0;
            load_idx   <= '0;
            load_seq_q <= '0;
        end else if (take) begin
            active     <= 1'b1;
            store_seq  <= st_seq;
            load_idx   <= ld_idx;
            load_seq_q <= ld_seq;
        end else if (release_i) begin
            active     <= 1'b0;
        end
    end
endmodule

// File: rtl/fwd_check_top.sv
module fwd_check_top
    import fwd_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 64,
    parameter int SQ_DEPTH = 8,
    parameter int LQ_DEPTH = 8,
    parameter int SEQW     = 16,
    localparam int SQW     = $clog2(SQ_DEPTH),
    localparam int LQW     = $clog2(LQ_DEPTH),
    localparam int SZW     = $clog2(DW / 8) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_req,
    input  logic [AW-1:0]   ld_addr,
    input  logic [SZW-1:0]  ld_size,
    input  logic [SQW-1:0]  ld_sq_idx,
    input  logic [LQW-1:0]  ld_idx,
    input  logic [SEQW-1:0] ld_seq,
    input  logic            ld_uncache,
    input  logic            ld_at_head,
    input  logic            ld_commit_ok,
    input  logic [SQW-1:0]  wb_ptr,
    input  logic            cache_blocked,
    output logic [SQW-1:0]  sq_rd_idx,
    input  logic [AW-1:0]   sq_rd_addr,
    input  logic [SZW-1:0]  sq_rd_size,
    input  logic [DW-1:0]   sq_rd_data,
    input  logic            sq_rd_done,
    input  logic [SEQW-1:0] sq_rd_seq,
    output logic            busy,
    output logic            rsp_valid,
    output logic [2:0]      rsp_kind,
    output logic [DW-1:0]   rsp_data,
    output logic            ld_blocked,
    input  logic            blk_ack,
    output logic            stall_active,
    output logic [SEQW-1:0] stall_store_seq,
    output logic [LQW-1:0]  stall_load_idx,
    input  logic            stall_release
);
    fsm_e            state_q, state_d;
    logic [AW-1:0]   l_addr_q;
    logic [SZW-1:0]  l_size_q;
    logic [LQW-1:0]  l_idx_q;
    logic [SEQW-1:0] l_seq_q;
    logic [SQW-1:0]  cur_q, prev_idx;
    outcome_e        rsp_kind_q;
    logic [DW-1:0]   rsp_data_q;
    logic            blocked_q;

    overlap_e        ov;
    logic [DW-1:0]   aligned;
    logic            accept, bad_uncache;
    logic            at_end, hit_full, hit_live_part, decide;

    // ---------------------------------------------------------------
    // Combinational search step
    // ---------------------------------------------------------------
    assign prev_idx  = (cur_q == '0) ? SQW'(SQ_DEPTH - 1) : cur_q - 1'b1;
    assign sq_rd_idx = prev_idx;

    fwd_overlap #(.AW(AW), .SZW(SZW)) u_overlap (
        .ld_addr (l_addr_q),
        .ld_size (l_size_q),
        .st_addr (sq_rd_addr),
        .st_size (sq_rd_size),
        .ov      (ov)
    );

    fwd_align #(.AW(AW), .DW(DW), .SZW(SZW)) u_align (
        .st_data  (sq_rd_data),
        .st_size  (sq_rd_size),
        .ld_addr  (l_addr_q),
        .ld_size  (l_size_q),
        .fwd_data (aligned)
    );

    always_comb begin
        accept        = (state_q == ST_IDLE) && ld_req;
        bad_uncache   = ld_uncache && !(ld_at_head && ld_commit_ok);
        at_end        = (cur_q == wb_ptr);
        hit_full      = !at_end && (ov == OV_FULL);
        hit_live_part = !at_end && (ov == OV_PART) && !sq_rd_done;
        decide        = at_end || hit_full || hit_live_part;
    end

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = bad_uncache ? ST_RESP : ST_SCAN;
            ST_SCAN: if (decide) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // Load capture, scan pointer and result registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_addr_q   <= '0;
            l_size_q   <= '0;
            l_idx_q    <= '0;
            l_seq_q    <= '0;
            cur_q      <= '0;
            rsp_kind_q <= OUT_MEM;
            rsp_data_q <= '0;
        end else begin
            if (accept) begin
                l_addr_q <= ld_addr;
                l_size_q <= ld_size;
                l_idx_q  <= ld_idx;
                l_seq_q  <= ld_seq;
                cur_q    <= ld_sq_idx;
                if (bad_uncache) begin
                    rsp_kind_q <= OUT_FAULT;
                    rsp_data_q <= '0;
                end
            end
            if (state_q == ST_SCAN) begin
                if (at_end) begin
                    rsp_kind_q <= cache_blocked ? OUT_BLOCKED : OUT_MEM;
                    rsp_data_q <= '0;
                end else if (hit_full) begin
                    rsp_kind_q <= OUT_FWD;
                    rsp_data_q <= aligned;
                end else if (hit_live_part) begin
                    rsp_kind_q <= OUT_RETRY;
                    rsp_data_q <= '0;
                end else begin
                    cur_q <= prev_idx;
                end
            end
        end
    end

    // ---------------------------------------------------------------
    // Sticky blocked flag
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                             blocked_q <= 1'b0;
        else if ((state_q == ST_SCAN) && at_end && cache_blocked) blocked_q <= 1'b1;
        else if (blk_ack)                                        blocked_q <= 1'b0;
    end

    // ---------------------------------------------------------------
    // Oldest-stalled-load record
    // ---------------------------------------------------------------
    fwd_stall_rec #(.SEQW(SEQW), .LQW(LQW)) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .retry_evt ((state_q == ST_SCAN) && hit_live_part),
        .ld_seq    (l_seq_q),
        .ld_idx    (l_idx_q),
        .st_seq    (sq_rd_seq),
        .release_i (stall_release),
        .active    (stall_active),
        .store_seq (stall_store_seq),
        .load_idx  (stall_load_idx)
    );

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        busy       = (state_q != ST_IDLE);
        rsp_valid  = (state_q == ST_RESP);
        rsp_kind   = rsp_kind_q;
        rsp_data   = rsp_data_q;
        ld_blocked = blocked_q;
    end
endmodule

// File: rtl/fwd_check_sva.sv
module fwd_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       ld_req,
    input logic       busy,
    input logic       rsp_valid,
    input logic [2:0] rsp_kind,
    input logic       ld_blocked,
    input logic       stall_active,
    input logic       stall_release
);
    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !busy) |=> busy);

    assert_fault_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd3) |-> $past(ld_req && !busy));

    assert_block_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd4) |-> ld_blocked);

    assert_stall_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_active) |-> (rsp_valid && rsp_kind == 3'd2));

    assert_stall_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_active) |-> $past(stall_release));
endmodule

bind fwd_check_top fwd_check_sva u_sva (.*);

// File: tb/tb_fwd_check_top.sv
module tb_fwd_check_top;
    localparam int AW = 16, DW = 64, SEQW = 16, SQW = 3, LQW = 3, SZW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic            ld_req = 0, ld_uncache = 0, ld_at_head = 0, ld_commit_ok = 0;
    logic [AW-1:0]   ld_addr = '0;
    logic [SZW-1:0]  ld_size = '0;
    logic [SQW-1:0]  ld_sq_idx = '0, wb_ptr = '0;
    logic [LQW-1:0]  ld_idx = '0;
    logic [SEQW-1:0] ld_seq = '0;
    logic            cache_blocked = 0, blk_ack = 0, stall_release = 0;
    logic [SQW-1:0]  sq_rd_idx;
    logic [AW-1:0]   sq_rd_addr;
    logic [SZW-1:0]  sq_rd_size;
    logic [DW-1:0]   sq_rd_data;
    logic            sq_rd_done;
    logic [SEQW-1:0] sq_rd_seq;
    logic            busy, rsp_valid, ld_blocked, stall_active;
    logic [2:0]      rsp_kind;
    logic [DW-1:0]   rsp_data;
    logic [SEQW-1:0] stall_store_seq;
    logic [LQW-1:0]  stall_load_idx;

    // store queue model
    logic [AW-1:0]   m_addr [8];
    logic [SZW-1:0]  m_size [8];
    logic [DW-1:0]   m_data [8];
    logic            m_done [8];
    logic [SEQW-1:0] m_seq  [8];

    always_comb begin
        sq_rd_addr = m_addr[sq_rd_idx];
        sq_rd_size = m_size[sq_rd_idx];
        sq_rd_data = m_data[sq_rd_idx];
        sq_rd_done = m_done[sq_rd_idx];
        sq_rd_seq  = m_seq[sq_rd_idx];
    end

    fwd_check_top dut (.*);

    int total = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_load(input logic [15:0] a, input logic [3:0] s, input logic [2:0] sqi,
                            input logic [2:0] wb, input logic [15:0] seq, input logic [2:0] lqi,
                            input logic unc, input logic head, input logic rdy,
                            output logic [2:0] k, output logic [63:0] d, output int lat);
        @(negedge clk);
        ld_addr = a; ld_size = s; ld_sq_idx = sqi; wb_ptr = wb; ld_seq = seq; ld_idx = lqi;
        ld_uncache = unc; ld_at_head = head; ld_commit_ok = rdy; ld_req = 1;
        @(negedge clk);
        ld_req = 0;
        lat = 1;
        while (!rsp_valid && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        if (lat >= 64) chk("R9 response timeout", 64'd0, 64'd1);
        k = rsp_kind;
        d = rsp_data;
    endtask

    typedef struct packed {
        logic [15:0] addr; logic [3:0] size; logic [2:0] sqi; logic [2:0] wb;
        logic [15:0] seq;  logic [2:0] lqi;  logic [2:0] kind; logic [63:0] data;
        logic sact; logic [15:0] sseq; logic [2:0] slidx;
    } vec_t;

    // R3 R4 R5 R6 R7 R8 vectors against one store image
    localparam vec_t TBL [15] = '{
        '{16'h0100, 4'd4, 3'd6, 3'd0, 16'd100, 3'd0, 3'd1, 64'h44332211, 1'b0, 16'd0,  3'd0},
        '{16'h0104, 4'd4, 3'd6, 3'd0, 16'd101, 3'd1, 3'd1, 64'hCAFEF00D, 1'b0, 16'd0,  3'd0},
        '{16'h0106, 4'd2, 3'd6, 3'd0, 16'd102, 3'd2, 3'd1, 64'hCAFE,     1'b0, 16'd0,  3'd0},
        '{16'h0102, 4'd4, 3'd6, 3'd0, 16'd50,  3'd3, 3'd2, 64'h0,        1'b1, 16'd13, 3'd3},
        '{16'h0404, 4'd4, 3'd6, 3'd0, 16'd103, 3'd4, 3'd1, 64'h01234567, 1'b1, 16'd13, 3'd3},
        '{16'h0406, 4'd4, 3'd6, 3'd0, 16'd104, 3'd5, 3'd0, 64'h0,        1'b1, 16'd13, 3'd3},
        '{16'h0600, 4'd8, 3'd6, 3'd0, 16'd105, 3'd6, 3'd0, 64'h0,        1'b1, 16'd13, 3'd3},
        '{16'h0300, 4'd4, 3'd6, 3'd0, 16'd106, 3'd7, 3'd0, 64'h0,        1'b1, 16'd13, 3'd3},
        '{16'h0500, 4'd2, 3'd6, 3'd0, 16'd107, 3'd0, 3'd1, 64'hBEEF,     1'b1, 16'd13, 3'd3},
        '{16'h0501, 4'd2, 3'd6, 3'd0, 16'd60,  3'd1, 3'd2, 64'h0,        1'b1, 16'd13, 3'd3},
        '{16'h00FC, 4'd8, 3'd6, 3'd0, 16'd40,  3'd2, 3'd2, 64'h0,        1'b1, 16'd10, 3'd2},
        '{16'h0101, 4'd1, 3'd6, 3'd0, 16'd108, 3'd3, 3'd1, 64'h22,       1'b1, 16'd10, 3'd2},
        '{16'h0702, 4'd2, 3'd2, 3'd6, 16'd109, 3'd4, 3'd1, 64'h1111,     1'b1, 16'd10, 3'd2},
        '{16'h0100, 4'd4, 3'd6, 3'd1, 16'd110, 3'd5, 3'd0, 64'h0,        1'b1, 16'd10, 3'd2},
        '{16'h0500, 4'd2, 3'd3, 3'd3, 16'd111, 3'd6, 3'd0, 64'h0,        1'b1, 16'd10, 3'd2}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin : main
        logic [2:0] k; logic [63:0] d; int lat; int nrsp; logic [2:0] k1;
        m_addr[0] = 16'h0100; m_size[0] = 4'd8; m_data[0] = 64'h8877665544332211; m_done[0] = 0; m_seq[0] = 16'd10;
        m_addr[1] = 16'h0200; m_size[1] = 4'd4; m_data[1] = 64'hDDCCBBAA;         m_done[1] = 0; m_seq[1] = 16'd11;
        m_addr[2] = 16'h0300; m_size[2] = 4'd0; m_data[2] = 64'hFFFFFFFF;         m_done[2] = 0; m_seq[2] = 16'd12;
        m_addr[3] = 16'h0104; m_size[3] = 4'd4; m_data[3] = 64'hCAFEF00D;         m_done[3] = 0; m_seq[3] = 16'd13;
        m_addr[4] = 16'h0400; m_size[4] = 4'd8; m_data[4] = 64'h0123456789ABCDEF; m_done[4] = 1; m_seq[4] = 16'd14;
        m_addr[5] = 16'h0500; m_size[5] = 4'd2; m_data[5] = 64'hBEEF;             m_done[5] = 0; m_seq[5] = 16'd15;
        m_addr[6] = 16'h0300; m_size[6] = 4'd8; m_data[6] = 64'h5A5A5A5A5A5A5A5A; m_done[6] = 0; m_seq[6] = 16'd16;
        m_addr[7] = 16'h0700; m_size[7] = 4'd4; m_data[7] = 64'h11112222;         m_done[7] = 0; m_seq[7] = 16'd17;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {63'd0, busy}, 64'd0);
        chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R1 stall_active", {63'd0, stall_active}, 64'd0);
        chk("R1 ld_blocked", {63'd0, ld_blocked}, 64'd0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < 15; i++) begin
            run_load(TBL[i].addr, TBL[i].size, TBL[i].sqi, TBL[i].wb, TBL[i].seq, TBL[i].lqi,
                     1'b0, 1'b0, 1'b0, k, d, lat);
            chk($sformatf("R3/R5/R6/R8 vec%0d kind", i), {61'd0, k}, {61'd0, TBL[i].kind});
            chk($sformatf("R5 vec%0d data", i), d, TBL[i].data);
            chk($sformatf("R7 vec%0d stall_active", i), {63'd0, stall_active}, {63'd0, TBL[i].sact});
            if (TBL[i].sact) begin
                chk($sformatf("R7 vec%0d store seq", i), {48'd0, stall_store_seq}, {48'd0, TBL[i].sseq});
                chk($sformatf("R7 vec%0d load idx", i), {61'd0, stall_load_idx}, {61'd0, TBL[i].slidx});
            end
        end

        // R9 latency: fault after one cycle, first-entry hit after two
        run_load(16'h0500, 4'd2, 3'd6, 3'd0, 16'd120, 3'd0, 1'b0, 1'b0, 1'b0, k, d, lat);
        chk("R9 first-entry forward latency", 64'(lat), 64'd2);
        // R2 uncacheable not at head
        run_load(16'h0104, 4'd4, 3'd6, 3'd0, 16'd121, 3'd1, 1'b1, 1'b0, 1'b1, k, d, lat);
        chk("R2 not head kind", {61'd0, k}, 64'd3);
        chk("R9 fault latency", 64'(lat), 64'd1);
        // R2 uncacheable at head but not ready
        run_load(16'h0104, 4'd4, 3'd6, 3'd0, 16'd122, 3'd1, 1'b1, 1'b1, 1'b0, k, d, lat);
        chk("R2 not ready kind", {61'd0, k}, 64'd3);
        // R2 eligible uncacheable is searched
        run_load(16'h0104, 4'd4, 3'd6, 3'd0, 16'd123, 3'd1, 1'b1, 1'b1, 1'b1, k, d, lat);
        chk("R2 eligible kind", {61'd0, k}, 64'd1);
        chk("R2 eligible data", d, 64'hCAFEF00D);

        // R8 blocked cache and sticky flag
        cache_blocked = 1;
        run_load(16'h0600, 4'd8, 3'd6, 3'd0, 16'd124, 3'd2, 1'b0, 1'b0, 1'b0, k, d, lat);
        chk("R8 blocked kind", {61'd0, k}, 64'd4);
        cache_blocked = 0;
        repeat (3) @(negedge clk);
        chk("R8 flag held", {63'd0, ld_blocked}, 64'd1);
        blk_ack = 1;
        @(negedge clk);
        blk_ack = 0;
        chk("R8 flag cleared", {63'd0, ld_blocked}, 64'd0);

        // R7 release, then a young load sets the empty record
        stall_release = 1;
        @(negedge clk);
        stall_release = 0;
        chk("R7 released", {63'd0, stall_active}, 64'd0);
        run_load(16'h0102, 4'd4, 3'd6, 3'd0, 16'd900, 3'd5, 1'b0, 1'b0, 1'b0, k, d, lat);
        chk("R7 refill active", {63'd0, stall_active}, 64'd1);
        chk("R7 refill load idx", {61'd0, stall_load_idx}, 64'd5);

        // R9 ld_req ignored while busy
        @(negedge clk);
        ld_addr = 16'h0600; ld_size = 4'd8; ld_sq_idx = 3'd6; wb_ptr = 3'd0;
        ld_uncache = 0; ld_req = 1;
        @(negedge clk);
        ld_uncache = 1; ld_at_head = 0;
        @(negedge clk);
        ld_req = 0; ld_uncache = 0;
        nrsp = 0; k1 = 3'd7;
        for (int c = 0; c < 20; c++) begin
            if (rsp_valid) begin nrsp++; k1 = rsp_kind; end
            @(negedge clk);
        end
        chk("R9 one response while busy", 64'(nrsp), 64'd1);
        chk("R9 ignored request kind", {61'd0, k1}, 64'd0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule